// File: doc/BRIEF.md
# Memory Tester Control and Status Registers

This block is the software-facing register file of a memory test engine. A 32-bit memory-mapped bus with read, write and byte-enable strobes reaches a small set of registers. These registers steer the test sequencer: its burst length, the top of the tested address range, the refresh interval and a set of mode switches. The same registers report the sequencer's outcome, the memory controller's calibration state and the sequencer's error tally back to software.

The control word holds two kinds of bit. Action bits (sequencer reset, test start, controller reset) act only when they go from 0 to 1, so software writes 1 and then 0. Mode bits (manual-access enable, random addressing, single outstanding read, auto precharge) are plain levels that drive outputs for as long as they are set. The controller reset request is stretched so that the memory controller always sees it for a guaranteed minimum number of cycles, however briefly software holds the bit. Any address at 0x40 or above belongs to a manual-access window. This block only flags such requests.

Top module: `memtest_csr`

## Requirements
- R1: After reset the burst count is DEF_BURST (4), the address limit is DEF_LIMIT (0x3FFFF80), the refresh period is DEF_REFR (1000), the control word reads 0, and all pulse and mode outputs are low.
- R2: A write updates only the byte lanes whose byte enable is set. Lane b covers data bits 8b+7..8b. Bits above a register's width are dropped: the burst count at 0x0C is 7 bits and the address limit at 0x10 is 26 bits.
- R3: `bus_ardy` is high in every cycle that carries a read or write. `bus_drdy` is high, with the read data, exactly in the cycle after each read and low otherwise.
- R4: Reads from offsets that map to no register (for example 0x1C or 0x40) return zero. Writes to those offsets, to the status word (0x04), to the error count (0x08) or to the default refresh (0x18) change nothing.
- R5: Control bit 0 at offset 0x00 makes `seq_reset` high for exactly one cycle when the bit goes from 0 to 1. Writing 1 while the bit is already 1 produces no pulse.
- R6: Control bit 2 makes `seq_run` high for exactly one cycle on each 0-to-1 transition of that bit.
- R7: Control bits 3, 4, 5 and 6 drive `man_en`, `rand_addr`, `single_read` and `auto_pre` as levels, and they read back at the same positions.
- R8: The status word at 0x04 holds these bits: bit 0 sequencer done, bit 1 sequencer pass, bit 2 ECC flag, bit 3 calibration success, bit 4 calibration failure, bit 5 memory ready. All other bits are 0.
- R9: The ECC flag (status bit 2) sets when `ecc_irq` is seen high and stays set after the input drops. It is cleared by the sequencer reset action of R5.
- R10: `ctrl_rst_req` is high while control bit 1 is 1. After a 0-to-1 transition of that bit it stays high for at least RST_MIN (4) cycles in total, even if the bit is cleared on the next cycle.
- R11: Offset 0x08 returns the `err_cnt` input.
- R12: `win_sel` is high exactly when a read or write targets an offset of 0x40 or above.
- R13: The refresh period at 0x14 is DATA_W bits wide, drives `refr_period`, and is reloaded with the default value (also readable at 0x18) by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | BUS_AW | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W/8 | Byte enables for writes |
| bus_ardy | output | 1 | Request accepted |
| bus_rdata | output | DATA_W | Read data |
| bus_drdy | output | 1 | Read data valid |
| win_sel | output | 1 | Request targets the manual-access window |
| seq_reset | output | 1 | One-cycle sequencer reset pulse |
| seq_run | output | 1 | One-cycle test start pulse |
| man_en | output | 1 | Manual-access enable level |
| rand_addr | output | 1 | Random addressing level |
| single_read | output | 1 | One read in flight level |
| auto_pre | output | 1 | Auto precharge level |
| seq_done | input | 1 | Sequencer finished |
| seq_pass | input | 1 | Sequencer found no errors |
| ecc_irq | input | 1 | ECC error indication |
| cal_ok | input | 1 | Calibration succeeded |
| cal_fail | input | 1 | Calibration failed |
| mem_ready | input | 1 | Memory controller ready |
| err_cnt | input | DATA_W | Sequencer error tally |
| burst_cnt | output | BURST_W | Burst length for the test |
| addr_limit | output | LIMIT_W | Upper limit of the tested range |
| refr_period | output | DATA_W | Refresh interval |
| ctrl_rst_req | output | 1 | Stretched memory-controller reset request |

## Verification
The hardest case to reach is the stretched controller reset request. Software must set the bit and clear it on the very next cycle, so that the bit's own level covers only one cycle and the stretch counter alone must supply the rest of the minimum length. The bench issues two back-to-back writes with no idle cycle between them and counts every cycle the request stays high. It also checks a long hold, where the level outlasts the counter. Clearing the sticky ECC flag needs a similar ordering: the flag is latched first, then the reset edge is written, then one idle cycle is left before the read-back.

// File: rtl/memtest_csr_pkg.sv
package memtest_csr_pkg;
    // byte offsets of the register slots
    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_STAT  = 'h04;
    localparam int OFS_ERR   = 'h08;
    localparam int OFS_BURST = 'h0C;
    localparam int OFS_LIMIT = 'h10;
    localparam int OFS_REFR  = 'h14;
    localparam int OFS_DREFR = 'h18;
    localparam int OFS_WIN   = 'h40;

    // control word bit positions
    localparam int CB_RST    = 0;
    localparam int CB_CRST   = 1;
    localparam int CB_RUN    = 2;
    localparam int CB_MAN    = 3;
    localparam int CB_RAND   = 4;
    localparam int CB_SINGLE = 5;
    localparam int CB_APRE   = 6;
    localparam int CTRL_W    = 7;

    // edge detector lanes
    localparam int EL_RST  = 0;
    localparam int EL_RUN  = 1;
    localparam int EL_CRST = 2;
    localparam int EL_W    = 3;
endpackage

// File: rtl/memtest_csr_edge.sv
module memtest_csr_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_lane
        assign rise[i] = lvl[i] & ~prev_q[i];
    end
endmodule

// File: rtl/memtest_csr_stretch.sv
module memtest_csr_stretch #(
    parameter int MIN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic trig,
    output logic req
);
    localparam int CW = $clog2(MIN_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (trig)              cnt_d = CW'(MIN_CYC - 1);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign req = lvl | (cnt_q != '0);
endmodule

// File: rtl/memtest_csr.sv
module memtest_csr
    import memtest_csr_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int BUS_AW    = 16,
    parameter int BURST_W   = 7,
    parameter int LIMIT_W   = 26,
    parameter int DEF_BURST = 4,
    parameter int DEF_LIMIT = 2**26 - 2**7,
    parameter int DEF_REFR  = 1000,
    parameter int RST_MIN   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [BUS_AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic [DATA_W/8-1:0]   bus_be,
    output logic                  bus_ardy,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_drdy,
    output logic                  win_sel,
    output logic                  seq_reset,
    output logic                  seq_run,
    output logic                  man_en,
    output logic                  rand_addr,
    output logic                  single_read,
    output logic                  auto_pre,
    input  logic                  seq_done,
    input  logic                  seq_pass,
    input  logic                  ecc_irq,
    input  logic                  cal_ok,
    input  logic                  cal_fail,
    input  logic                  mem_ready,
    input  logic [DATA_W-1:0]     err_cnt,
    output logic [BURST_W-1:0]    burst_cnt,
    output logic [LIMIT_W-1:0]    addr_limit,
    output logic [DATA_W-1:0]     refr_period,
    output logic                  ctrl_rst_req
);
    localparam int BE_W = DATA_W / 8;

    typedef struct packed {
        logic [CTRL_W-1:0]  ctrl;
        logic [BURST_W-1:0] burst;
        logic [LIMIT_W-1:0] limit;
        logic [DATA_W-1:0]  refr;
        logic               ecc;
        logic [DATA_W-1:0]  rdata;
        logic               drdy;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [EL_W-1:0] edge_lvl, edge_rise;

    function automatic logic [DATA_W-1:0] merge_be(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [BE_W-1:0]   be
    );
        logic [DATA_W-1:0] r;
        r = old_v;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return r;
    endfunction

    // action-bit edge detection and reset stretching
    assign edge_lvl[EL_RST]  = regs_q.ctrl[CB_RST];
    assign edge_lvl[EL_RUN]  = regs_q.ctrl[CB_RUN];
    assign edge_lvl[EL_CRST] = regs_q.ctrl[CB_CRST];

    memtest_csr_edge #(.W(EL_W)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (edge_lvl),
        .rise (edge_rise)
    );

    memtest_csr_stretch #(.MIN_CYC(RST_MIN)) u_stretch (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (regs_q.ctrl[CB_CRST]),
        .trig (edge_rise[EL_CRST]),
        .req  (ctrl_rst_req)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.drdy  = bus_rd;
        regs_d.rdata = '0;

        if (bus_rd) begin
            if (bus_addr == BUS_AW'(OFS_CTRL))       regs_d.rdata = DATA_W'(regs_q.ctrl);
            else if (bus_addr == BUS_AW'(OFS_STAT))  regs_d.rdata = DATA_W'({mem_ready, cal_fail, cal_ok,
                                                                              regs_q.ecc, seq_pass, seq_done});
            else if (bus_addr == BUS_AW'(OFS_ERR))   regs_d.rdata = err_cnt;
            else if (bus_addr == BUS_AW'(OFS_BURST)) regs_d.rdata = DATA_W'(regs_q.burst);
            else if (bus_addr == BUS_AW'(OFS_LIMIT)) regs_d.rdata = DATA_W'(regs_q.limit);
            else if (bus_addr == BUS_AW'(OFS_REFR))  regs_d.rdata = regs_q.refr;
            else if (bus_addr == BUS_AW'(OFS_DREFR)) regs_d.rdata = DATA_W'(DEF_REFR);
        end

        if (bus_wr) begin
            if (bus_addr == BUS_AW'(OFS_CTRL))
                regs_d.ctrl = CTRL_W'(merge_be(DATA_W'(regs_q.ctrl), bus_wdata, bus_be));
            else if (bus_addr == BUS_AW'(OFS_BURST))
                regs_d.burst = BURST_W'(merge_be(DATA_W'(regs_q.burst), bus_wdata, bus_be));
            else if (bus_addr == BUS_AW'(OFS_LIMIT))
                regs_d.limit = LIMIT_W'(merge_be(DATA_W'(regs_q.limit), bus_wdata, bus_be));
            else if (bus_addr == BUS_AW'(OFS_REFR))
                regs_d.refr = merge_be(regs_q.refr, bus_wdata, bus_be);
        end

        // sticky ECC flag; the reset action wins over a new indication
        regs_d.ecc = regs_q.ecc | ecc_irq;
        if (edge_rise[EL_RST]) regs_d.ecc = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q       <= '0;
            regs_q.burst <= BURST_W'(DEF_BURST);
            regs_q.limit <= LIMIT_W'(DEF_LIMIT);
            regs_q.refr  <= DATA_W'(DEF_REFR);
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_ardy    = bus_rd | bus_wr;
    assign bus_rdata   = regs_q.rdata;
    assign bus_drdy    = regs_q.drdy;
    assign win_sel     = (bus_rd | bus_wr) && (bus_addr >= BUS_AW'(OFS_WIN));
    assign seq_reset   = edge_rise[EL_RST];
    assign seq_run     = edge_rise[EL_RUN];
    assign man_en      = regs_q.ctrl[CB_MAN];
    assign rand_addr   = regs_q.ctrl[CB_RAND];
    assign single_read = regs_q.ctrl[CB_SINGLE];
    assign auto_pre    = regs_q.ctrl[CB_APRE];
    assign burst_cnt   = regs_q.burst;
    assign addr_limit  = regs_q.limit;
    assign refr_period = regs_q.refr;
endmodule

// File: rtl/memtest_csr_chk.sv
module memtest_csr_chk #(
    parameter int DATA_W  = 32,
    parameter int RST_MIN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_ardy,
    input logic              bus_drdy,
    input logic              seq_reset,
    input logic              seq_run,
    input logic              man_en,
    input logic              rand_addr,
    input logic              single_read,
    input logic              auto_pre,
    input logic [DATA_W-1:0] refr_period,
    input logic              ctrl_rst_req
);
    localparam int LW = $clog2(RST_MIN + 1) + 1;

    logic [LW-1:0] run_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           run_len_q <= '0;
        else if (!ctrl_rst_req)               run_len_q <= '0;
        else if (run_len_q < LW'(RST_MIN))    run_len_q <= run_len_q + 1'b1;
    end

    // R3: every request is accepted at once
    a_r3_ardy: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> bus_ardy);

    // R3: data-ready follows a read by one cycle and nothing else
    a_r3_drdy_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_drdy);
    a_r3_no_stray_drdy: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_drdy);

    // R5 / R6: action pulses last one cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        seq_reset |=> !seq_reset);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        seq_run |=> !seq_run);

    // R7: mode levels change only through a write
    a_r7_modes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable({man_en, rand_addr, single_read, auto_pre}));

    // R13: refresh period changes only through a write
    a_r13_refr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(refr_period));

    // R10: controller reset request never shorter than the minimum
    a_r10_min_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_rst_req) |-> (run_len_q >= LW'(RST_MIN)));
endmodule

bind memtest_csr memtest_csr_chk #(.DATA_W(DATA_W), .RST_MIN(RST_MIN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_ardy    (bus_ardy),
    .bus_drdy    (bus_drdy),
    .seq_reset   (seq_reset),
    .seq_run     (seq_run),
    .man_en      (man_en),
    .rand_addr   (rand_addr),
    .single_read (single_read),
    .auto_pre    (auto_pre),
    .refr_period (refr_period),
    .ctrl_rst_req(ctrl_rst_req)
);

// File: tb/memtest_csr_tb_top.sv
module memtest_csr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RST_MIN    = 4;
    localparam logic [31:0] DEF_LIMIT = 32'h03FF_FF80;
    localparam logic [31:0] ERR_VAL   = 32'h00C0_FFEE;

    // {req tag, offset, write data, byte enables, expected read-back}
    localparam int NV = 15;
    localparam logic [87:0] TBL [NV] = '{
        {4'd2, 16'h000C, 32'hFFFF_FF15, 4'hF, 32'h0000_0015}, // R2 burst truncated to 7 bits
        {4'd2, 16'h000C, 32'h0000_007F, 4'h0, 32'h0000_0015}, // R2 no lanes enabled
        {4'd2, 16'h000C, 32'h0000_00FF, 4'h1, 32'h0000_007F}, // R2 lane 0
        {4'd2, 16'h0010, 32'h1234_5678, 4'h3, 32'h03FF_5678}, // R2 lanes 0-1 of limit
        {4'd2, 16'h0010, 32'hAABB_CCDD, 4'h4, 32'h03BB_5678}, // R2 lane 2 only
        {4'd2, 16'h0010, 32'hFFFF_FFFF, 4'h8, 32'h03BB_5678}, // R2 top bits beyond 26 dropped
        {4'd13,16'h0014, 32'hDEAD_BEEF, 4'hF, 32'hDEAD_BEEF}, // R13 full width refresh
        {4'd2, 16'h0014, 32'h0000_0000, 4'h2, 32'hDEAD_00EF}, // R2 lane 1 of refresh
        {4'd4, 16'h0018, 32'h1234_5678, 4'hF, 32'h0000_03E8}, // R4 default refresh read-only
        {4'd4, 16'h001C, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000}, // R4 unmapped
        {4'd4, 16'h0040, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000}, // R4 window reads zero
        {4'd11,16'h0008, 32'h1111_1111, 4'hF, 32'h00C0_FFEE}, // R11 error count, write ignored
        {4'd7, 16'h0000, 32'h0000_0078, 4'hF, 32'h0000_0078}, // R7 all mode bits
        {4'd2, 16'h0000, 32'h0000_0000, 4'h0, 32'h0000_0078}, // R2 control without lanes
        {4'd2, 16'h0000, 32'h0000_0000, 4'h1, 32'h0000_0000}  // R2 control lane 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic        bus_ardy, bus_drdy, win_sel;
    logic [31:0] bus_rdata;
    logic        seq_reset, seq_run, man_en, rand_addr, single_read, auto_pre;
    logic        seq_done = 0, seq_pass = 0, ecc_irq = 0, cal_ok = 0, cal_fail = 0, mem_ready = 0;
    logic [31:0] err_cnt = ERR_VAL;
    logic [6:0]  burst_cnt;
    logic [25:0] addr_limit;
    logic [31:0] refr_period;
    logic        ctrl_rst_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memtest_csr dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_ardy(bus_ardy), .bus_rdata(bus_rdata), .bus_drdy(bus_drdy),
        .win_sel(win_sel), .seq_reset(seq_reset), .seq_run(seq_run), .man_en(man_en),
        .rand_addr(rand_addr), .single_read(single_read), .auto_pre(auto_pre),
        .seq_done(seq_done), .seq_pass(seq_pass), .ecc_irq(ecc_irq), .cal_ok(cal_ok),
        .cal_fail(cal_fail), .mem_ready(mem_ready), .err_cnt(err_cnt),
        .burst_cnt(burst_cnt), .addr_limit(addr_limit), .refr_period(refr_period),
        .ctrl_rst_req(ctrl_rst_req)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    // tasks start and end just after a falling edge
    task automatic bus_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        #1 chk("R3 ardy on write", 32'(bus_ardy), 32'd1);
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 chk("R3 ardy on read", 32'(bus_ardy), 32'd1);
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        chk("R3 drdy after read", 32'(bus_drdy), 32'd1);
        d = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got timeout exp completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        chk("R1 burst", 32'(burst_cnt), 32'd4);
        chk("R1 limit", 32'(addr_limit), DEF_LIMIT);
        chk("R13 refresh default", refr_period, 32'd1000);
        chk("R1 pulses and modes", {26'd0, seq_reset, seq_run, man_en, rand_addr, single_read, auto_pre}, 32'd0);
        chk("R1 ctrl req", 32'(ctrl_rst_req), 32'd0);
        chk("R3 idle drdy", 32'(bus_drdy), 32'd0);
        bus_read(16'h0000, rv); chk("R1 ctrl word", rv, 32'd0);
        bus_read(16'h0004, rv); chk("R8 status idle", rv, 32'd0);
        @(negedge clk);
        chk("R3 drdy drops", 32'(bus_drdy), 32'd0);

        // register table walk
        for (int i = 0; i < NV; i++) begin
            logic [3:0] tg; logic [15:0] a; logic [31:0] d, e; logic [3:0] be;
            {tg, a, d, be, e} = TBL[i];
            bus_write(a, d, be);
            bus_read(a, rv);
            chk($sformatf("R%0d table entry %0d", tg, i), rv, e);
        end
        chk("R13 refresh port", refr_period, 32'hDEAD_00EF);
        chk("R2 limit port", 32'(addr_limit), 32'h03BB_5678);
        bus_read(16'h000C, rv); chk("R4 burst unchanged by window write", rv, 32'h7F);

        // R7 mode levels
        bus_write(16'h0000, 32'h28, 4'hF);
        chk("R7 modes 3 and 5", {28'd0, man_en, rand_addr, single_read, auto_pre}, 32'b1010);
        chk("R7 no action pulse", {30'd0, seq_reset, seq_run}, 32'd0);
        bus_write(16'h0000, 32'h50, 4'hF);
        chk("R7 modes 4 and 6", {28'd0, man_en, rand_addr, single_read, auto_pre}, 32'b0101);
        bus_write(16'h0000, 32'h00, 4'hF);

        // R5 reset action pulse on rising edge only
        bus_write(16'h0000, 32'h01, 4'hF);
        chk("R5 pulse high", 32'(seq_reset), 32'd1);
        @(negedge clk);
        chk("R5 pulse one cycle", 32'(seq_reset), 32'd0);
        bus_write(16'h0000, 32'h01, 4'hF);
        chk("R5 no retrigger while held", 32'(seq_reset), 32'd0);
        bus_write(16'h0000, 32'h00, 4'hF);

        // R6 run pulse
        bus_write(16'h0000, 32'h04, 4'hF);
        chk("R6 run pulse high", {30'd0, seq_run, seq_reset}, 32'b10);
        @(negedge clk);
        chk("R6 run pulse one cycle", 32'(seq_run), 32'd0);

        // R8 / R9 status layout and sticky ECC flag
        seq_done = 1; cal_ok = 1; mem_ready = 1;
        ecc_irq = 1; @(negedge clk); ecc_irq = 0;
        bus_read(16'h0004, rv); chk("R9 ecc latched", rv, 32'h2D);
        bus_read(16'h0004, rv); chk("R9 ecc sticky", rv, 32'h2D);
        seq_done = 0; seq_pass = 1; cal_ok = 0; cal_fail = 1; mem_ready = 0;
        bus_read(16'h0004, rv); chk("R8 status bits 1 4", rv, 32'h16);
        bus_write(16'h0000, 32'h01, 4'hF);
        @(negedge clk);
        bus_read(16'h0004, rv); chk("R9 ecc cleared by reset action", rv, 32'h12);
        bus_write(16'h0000, 32'h00, 4'hF);

        // R10 short request is stretched
        n = 0;
        bus_write(16'h0000, 32'h02, 4'hF);
        if (ctrl_rst_req) n++;
        bus_write(16'h0000, 32'h00, 4'hF);
        for (int k = 0; k < 20 && ctrl_rst_req; k++) begin
            n++;
            @(negedge clk);
        end
        chk("R10 stretched length", 32'(n), 32'(RST_MIN));

        // R10 long hold follows the level
        bus_write(16'h0000, 32'h02, 4'hF);
        repeat (8) @(negedge clk);
        chk("R10 held level", 32'(ctrl_rst_req), 32'd1);
        bus_write(16'h0000, 32'h00, 4'hF);
        chk("R10 drops after long hold", 32'(ctrl_rst_req), 32'd0);

        // R12 window select
        bus_rd = 1'b1; bus_addr = 16'h0040; #1;
        chk("R12 window base", 32'(win_sel), 32'd1);
        bus_addr = 16'h003C; #1;
        chk("R12 below window", 32'(win_sel), 32'd0);
        bus_addr = 16'hFFFC; #1;
        chk("R12 window top", 32'(win_sel), 32'd1);
        bus_rd = 1'b0; #1;
        chk("R12 no request", 32'(win_sel), 32'd0);
        bus_addr = 16'h0000;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule